// File: doc/BRIEF.md
# Mixed-Grain Reconfigurable Processing Tile

This block is one tile of a two-dimensional reconfigurable fabric. It exchanges tokens with its four nearest neighbours (up, left, right, down) over valid/ready channels. Each channel carries an 8-bit word and a 1-bit side signal. A static configuration word chooses up to two operand channels and an operation for the 8-bit unit. It also chooses which neighbour supplies the 1-bit lane bit, and what the single-bit unit does with that bit. The 1-bit lane carries carry and condition values. Chained tiles therefore form wide ripple-carry adders, and 1-bit logic can run next to the word datapath.

One output latch follows the function units. Its control is a two-state machine. `ST_EMPTY` moves to `ST_FULL` on transition `T_CAPTURE`, which happens when every selected input channel is valid. `ST_FULL` moves back to `ST_EMPTY` on transition `T_DRAIN`, which happens when the consumer asserts `out_ready`. Reset enters `ST_EMPTY`. When a preloaded token is configured, reset enters `ST_FULL` instead, so the tile can seed a ring with one token. The tile has three modes. Compute mode uses both function units. Forward mode copies a channel through unchanged. Select mode lets the lane bit steer a two-way multiplexer.

Top module: `mgpe_tile`

## Requirements
- R1: While `rst` is high on a clock edge, the latch is loaded as follows. If `cfg_init_tok`=1, `out_valid` becomes 1 with `out_data`=`cfg_init_data` and `out_bit`=`cfg_init_bit`. Otherwise `out_valid` becomes 0.
- R2: A token is accepted only in a cycle where the latch is empty and every required channel has `nb_valid` high. The required channels are operand A, operand B when used, and the lane channel when used. While the latch is full, or any required channel is not valid, every `nb_ready` is 0.
- R3: `cfg_op`=0 (add) gives `out_data` = A+B+cin and `out_bit` = carry out, when `cfg_bit_fn`=0. `cfg_op`=1 (subtract) gives A+~B+cin, with carry out 1 meaning no borrow.
- R4: `cfg_op`=2/3/4/5 gives A AND B, A OR B, A XOR B and A respectively. For these operations the unit flag is 0.
- R5: `cfg_op`=6 sets the flag to (A<B, unsigned). `cfg_op`=7 sets the flag to (A==B). In both cases `out_data`=A.
- R6: An accepted token appears on the outputs one cycle later. It holds `out_data`/`out_bit` stable while `out_ready` is 0, and it leaves the latch empty after the cycle in which `out_valid` and `out_ready` are both high.
- R7: `cfg_mode`=1 (forward) requires only channel `cfg_src_a`. It outputs that channel's word and side bit unchanged.
- R8: `cfg_mode`=2 (select) requires channels A, B and the lane. It outputs A when the lane bit is 1 and B when it is 0, with `out_bit` equal to the lane bit.
- R9: When `cfg_bit2wide`=1, operand B is replaced by the zero-extended lane bit. The lane channel becomes required, and channel `cfg_src_b` becomes neither required nor used.
- R10: In compute mode, `cfg_bit_fn` selects `out_bit`. The lane bit is x, and y is the side bit of channel A. The codes are: 0 = unit flag, 1 = x, 2 = NOT x, 3 = x AND y, 4 = x OR y, 5 = x XOR y, 6 = bit `cfg_res_idx` of the word result, 7 = constant 0.
- R11: Carry-in is the lane bit when `cfg_lane_en`=1, and `cfg_cin` otherwise. A lane bit that is not enabled has no effect on the sum.
- R12: Channel numbering is 0 = up, 1 = left, 2 = right, 3 = down, and channel i uses `nb_data[8i+7:8i]` and `nb_bit[i]`. At acceptance, `nb_ready` is 1 exactly on the required channels. Channels that are not required keep ready at 0, and their contents do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 compute, 1 forward, 2 select, 3 compute |
| cfg_op | input | 3 | Word operation code |
| cfg_src_a | input | 2 | Channel of operand A |
| cfg_src_b | input | 2 | Channel of operand B |
| cfg_use_b | input | 1 | Operand B channel required in compute mode |
| cfg_lane_src | input | 2 | Channel supplying the lane bit |
| cfg_lane_en | input | 1 | Lane channel required; lane bit is carry-in |
| cfg_bit2wide | input | 1 | Lane bit replaces operand B |
| cfg_cin | input | 1 | Constant carry-in when lane not enabled |
| cfg_bit_fn | input | 3 | Single-bit function code |
| cfg_res_idx | input | 3 | Result bit routed to the lane by function 6 |
| cfg_init_tok | input | 1 | Latch holds a token after reset |
| cfg_init_data | input | 8 | Word of the preloaded token |
| cfg_init_bit | input | 1 | Side bit of the preloaded token |
| nb_data | input | 32 | Neighbour words, 8 bits per channel |
| nb_bit | input | 4 | Neighbour side bits |
| nb_valid | input | 4 | Neighbour valid flags |
| nb_ready | output | 4 | Ready back to each neighbour |
| out_data | output | 8 | Latched result word |
| out_bit | output | 1 | Latched lane bit |
| out_valid | output | 1 | Latch holds a token |
| out_ready | input | 1 | Consumer accepts the token |

## Verification
The word unit is exercised with operand pairs that do and do not produce a carry, with subtraction that does and does not borrow, and with compares whose results are true and false. These cases separate the carry-out and flag paths from the word result. Each single-bit function is applied to lane and side bits chosen so that it produces a value none of its neighbours in the table would produce, and two different result-bit indices are routed out. Every channel that is not required is driven valid with junk data. This shows that readiness and the result depend only on the configured sources. Separate runs withhold one operand and stall the consumer, to check the accept condition and the hold behaviour.

// File: rtl/mgpe_pkg.sv
package mgpe_pkg;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_PASSA, OP_LTU, OP_EQ
    } wide_op_e;

    typedef enum logic [2:0] {
        BF_FLAG, BF_PASS, BF_NOT, BF_AND, BF_OR, BF_XOR, BF_RESBIT, BF_ZERO
    } bit_fn_e;

    typedef enum logic [1:0] {
        MD_COMPUTE, MD_FORWARD, MD_SELECT, MD_COMPUTE_ALT
    } tile_mode_e;

    typedef enum logic {
        ST_EMPTY, ST_FULL
    } latch_state_e;

endpackage

// File: rtl/mgpe_in_sel.sv
module mgpe_in_sel #(
    parameter int W    = 8,
    parameter int NDIR = 4,
    localparam int SW  = $clog2(NDIR)
) (
    input  logic [NDIR*W-1:0] nb_data,
    input  logic [NDIR-1:0]   nb_bit,
    input  logic [NDIR-1:0]   nb_valid,
    input  logic [SW-1:0]     src_a,
    input  logic [SW-1:0]     src_b,
    input  logic [SW-1:0]     lane_src,
    input  logic              need_b,
    input  logic              need_lane,
    output logic [W-1:0]      opa,
    output logic [W-1:0]      opb,
    output logic              ya,
    output logic              x,
    output logic [NDIR-1:0]   need_mask,
    output logic              all_ok
);

    assign opa = nb_data[src_a*W +: W];
    assign opb = nb_data[src_b*W +: W];
    assign ya  = nb_bit[src_a];
    assign x   = nb_bit[lane_src];

    // one requirement flag per neighbour channel
    for (genvar g = 0; g < NDIR; g++) begin : g_need
        assign need_mask[g] = (src_a == SW'(g))
                            | (need_b    && (src_b    == SW'(g)))
                            | (need_lane && (lane_src == SW'(g)));
    end

    assign all_ok = &(nb_valid | ~need_mask);

endmodule

// File: rtl/mgpe_wide_fu.sv
module mgpe_wide_fu
    import mgpe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  wide_op_e     op,
    output logic [W-1:0] res,
    output logic         flag
);

    logic [W:0] sum;

    always_comb begin
        sum  = '0;
        res  = a;
        flag = 1'b0;
        unique case (op)
            OP_ADD: begin
                sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
                res  = sum[W-1:0];
                flag = sum[W];
            end
            OP_SUB: begin
                sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
                res  = sum[W-1:0];
                flag = sum[W];
            end
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            OP_PASSA: res = a;
            OP_LTU:   flag = (a < b);
            OP_EQ:    flag = (a == b);
        endcase
    end

endmodule

// File: rtl/mgpe_bit_fu.sv
module mgpe_bit_fu
    import mgpe_pkg::*;
#(
    parameter int W   = 8,
    localparam int IW = $clog2(W)
) (
    input  tile_mode_e    mode,
    input  bit_fn_e       fn,
    input  logic [IW-1:0] idx,
    input  logic          x,
    input  logic          ya,
    input  logic          flag,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  res,
    output logic [W-1:0]  nxt_data,
    output logic          nxt_bit
);

    always_comb begin
        nxt_data = res;
        nxt_bit  = 1'b0;
        unique case (mode)
            MD_FORWARD: begin
                nxt_data = a;
                nxt_bit  = ya;
            end
            MD_SELECT: begin
                nxt_data = x ? a : b;
                nxt_bit  = x;
            end
            MD_COMPUTE, MD_COMPUTE_ALT: begin
                unique case (fn)
                    BF_FLAG:   nxt_bit = flag;
                    BF_PASS:   nxt_bit = x;
                    BF_NOT:    nxt_bit = ~x;
                    BF_AND:    nxt_bit = x & ya;
                    BF_OR:     nxt_bit = x | ya;
                    BF_XOR:    nxt_bit = x ^ ya;
                    BF_RESBIT: nxt_bit = res[idx];
                    BF_ZERO:   nxt_bit = 1'b0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mgpe_out_latch.sv
module mgpe_out_latch
    import mgpe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_tok,
    input  logic [W-1:0] init_data,
    input  logic         init_bit,
    input  logic         all_ok,
    input  logic [W-1:0] nxt_data,
    input  logic         nxt_bit,
    input  logic         out_ready,
    output logic         accept,
    output logic [W-1:0] out_data,
    output logic         out_bit,
    output logic         out_valid
);

    latch_state_e state, state_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= init_tok ? ST_FULL : ST_EMPTY;
        else     state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= init_data;
            out_bit  <= init_bit;
        end else if (accept) begin
            out_data <= nxt_data;
            out_bit  <= nxt_bit;
        end
    end

    // transitions: T_CAPTURE (empty -> full), T_DRAIN (full -> empty)
    always_comb begin
        state_n = state;
        unique case (state)
            ST_EMPTY: if (all_ok)    state_n = ST_FULL;
            ST_FULL:  if (out_ready) state_n = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_EMPTY: accept    = all_ok;
            ST_FULL:  out_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/mgpe_tile.sv
module mgpe_tile
    import mgpe_pkg::*;
#(
    parameter int W    = 8,
    parameter int NDIR = 4,
    localparam int SW  = $clog2(NDIR),
    localparam int IW  = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_op,
    input  logic [SW-1:0]     cfg_src_a,
    input  logic [SW-1:0]     cfg_src_b,
    input  logic              cfg_use_b,
    input  logic [SW-1:0]     cfg_lane_src,
    input  logic              cfg_lane_en,
    input  logic              cfg_bit2wide,
    input  logic              cfg_cin,
    input  logic [2:0]        cfg_bit_fn,
    input  logic [IW-1:0]     cfg_res_idx,
    input  logic              cfg_init_tok,
    input  logic [W-1:0]      cfg_init_data,
    input  logic              cfg_init_bit,
    input  logic [NDIR*W-1:0] nb_data,
    input  logic [NDIR-1:0]   nb_bit,
    input  logic [NDIR-1:0]   nb_valid,
    output logic [NDIR-1:0]   nb_ready,
    output logic [W-1:0]      out_data,
    output logic              out_bit,
    output logic              out_valid,
    input  logic              out_ready
);

    tile_mode_e mode;
    logic       is_fwd, is_sel, need_b, need_lane;
    logic [W-1:0]    opa, opb, opb_eff, wres, nxt_data;
    logic            ya, x, cin, wflag, nxt_bit, all_ok, accept;
    logic [NDIR-1:0] need_mask;

    assign mode      = tile_mode_e'(cfg_mode);
    assign is_fwd    = (mode == MD_FORWARD);
    assign is_sel    = (mode == MD_SELECT);
    assign need_b    = is_sel | (!is_fwd && cfg_use_b && !cfg_bit2wide);
    assign need_lane = is_sel | (!is_fwd && (cfg_lane_en || cfg_bit2wide));
    assign cin       = cfg_lane_en ? x : cfg_cin;
    assign opb_eff   = cfg_bit2wide ? {{(W-1){1'b0}}, x} : opb;
    assign nb_ready  = need_mask & {NDIR{accept}};

    mgpe_in_sel #(.W(W), .NDIR(NDIR)) u_sel (
        .nb_data(nb_data), .nb_bit(nb_bit), .nb_valid(nb_valid),
        .src_a(cfg_src_a), .src_b(cfg_src_b), .lane_src(cfg_lane_src),
        .need_b(need_b), .need_lane(need_lane),
        .opa(opa), .opb(opb), .ya(ya), .x(x),
        .need_mask(need_mask), .all_ok(all_ok)
    );

    mgpe_wide_fu #(.W(W)) u_wide (
        .a(opa), .b(opb_eff), .cin(cin), .op(wide_op_e'(cfg_op)),
        .res(wres), .flag(wflag)
    );

    mgpe_bit_fu #(.W(W)) u_bit (
        .mode(mode), .fn(bit_fn_e'(cfg_bit_fn)), .idx(cfg_res_idx),
        .x(x), .ya(ya), .flag(wflag), .a(opa), .b(opb), .res(wres),
        .nxt_data(nxt_data), .nxt_bit(nxt_bit)
    );

    mgpe_out_latch #(.W(W)) u_latch (
        .clk(clk), .rst(rst),
        .init_tok(cfg_init_tok), .init_data(cfg_init_data), .init_bit(cfg_init_bit),
        .all_ok(all_ok), .nxt_data(nxt_data), .nxt_bit(nxt_bit),
        .out_ready(out_ready), .accept(accept),
        .out_data(out_data), .out_bit(out_bit), .out_valid(out_valid)
    );

endmodule

// File: rtl/mgpe_tile_chk.sv
module mgpe_tile_chk #(
    parameter int W    = 8,
    parameter int NDIR = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_mode,
    input logic              cfg_init_tok,
    input logic [W-1:0]      cfg_init_data,
    input logic [NDIR-1:0]   nb_valid,
    input logic [NDIR-1:0]   nb_ready,
    input logic [W-1:0]      out_data,
    input logic              out_bit,
    input logic              out_valid,
    input logic              out_ready,
    input logic [W-1:0]      opa
);

    // R1: state right after reset follows the preload configuration
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_valid == cfg_init_tok) && (!cfg_init_tok || out_data == cfg_init_data))
        else $error("p_reset_state_r1");

    // R2: never hand ready to a channel that is not valid
    always @(posedge clk) begin
        if (!rst) begin
            p_ready_valid_r2: assert ((nb_ready & ~nb_valid) == '0)
                else $error("p_ready_valid_r2");
        end
    end

    // R2: a full latch accepts nothing
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (nb_ready == '0))
        else $error("p_full_blocks_r2");

    // R6: acceptance shows up on the next cycle
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (|nb_ready) |=> out_valid)
        else $error("p_capture_r6");

    // R6: stalled output holds
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_bit))
        else $error("p_hold_r6");

    // R6: handshake empties the latch
    p_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid)
        else $error("p_drain_r6");

    // R7: forward mode copies operand A
    p_forward_r7: assert property (@(posedge clk) disable iff (rst)
        ((|nb_ready) && cfg_mode == 2'd1) |=> (out_data == $past(opa)))
        else $error("p_forward_r7");

endmodule

bind mgpe_tile mgpe_tile_chk #(.W(W), .NDIR(NDIR)) u_chk (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .cfg_init_tok(cfg_init_tok), .cfg_init_data(cfg_init_data),
    .nb_valid(nb_valid), .nb_ready(nb_ready),
    .out_data(out_data), .out_bit(out_bit), .out_valid(out_valid),
    .out_ready(out_ready), .opa(opa)
);

// File: tb/sim_mgpe_tile.sv
module sim_mgpe_tile;
    localparam int W    = 8;
    localparam int NDIR = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst;
    logic [1:0] cfg_mode, cfg_src_a, cfg_src_b, cfg_lane_src;
    logic [2:0] cfg_op, cfg_bit_fn, cfg_res_idx;
    logic cfg_use_b, cfg_lane_en, cfg_bit2wide, cfg_cin;
    logic cfg_init_tok, cfg_init_bit;
    logic [W-1:0] cfg_init_data;
    logic [NDIR*W-1:0] nb_data;
    logic [NDIR-1:0] nb_bit, nb_valid, nb_ready;
    logic [W-1:0] out_data;
    logic out_bit, out_valid, out_ready;

    int n_chk = 0;
    int n_fail = 0;
    logic [W:0] exp_q[$];
    string tag_q[$];
    logic [W:0] mon_e;
    string mon_t;

    mgpe_tile #(.W(W), .NDIR(NDIR)) u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_op(cfg_op),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_use_b(cfg_use_b),
        .cfg_lane_src(cfg_lane_src), .cfg_lane_en(cfg_lane_en),
        .cfg_bit2wide(cfg_bit2wide), .cfg_cin(cfg_cin), .cfg_bit_fn(cfg_bit_fn),
        .cfg_res_idx(cfg_res_idx), .cfg_init_tok(cfg_init_tok),
        .cfg_init_data(cfg_init_data), .cfg_init_bit(cfg_init_bit),
        .nb_data(nb_data), .nb_bit(nb_bit), .nb_valid(nb_valid), .nb_ready(nb_ready),
        .out_data(out_data), .out_bit(out_bit), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected result {bit, word} from the requirements
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic ya,
                                         input logic [W-1:0] b, input logic x);
        logic [W:0] s;
        logic [W-1:0] r, bb;
        logic f, c, o;
        if (cfg_mode == 2'd1) return {ya, a};
        if (cfg_mode == 2'd2) return {x, x ? a : b};
        bb = cfg_bit2wide ? {{(W-1){1'b0}}, x} : b;
        c  = cfg_lane_en ? x : cfg_cin;
        r = a; f = 1'b0; s = '0;
        case (cfg_op)
            3'd0: begin s = {1'b0, a} + {1'b0, bb} + (W+1)'(c); r = s[W-1:0]; f = s[W]; end
            3'd1: begin s = {1'b0, a} + {1'b0, ~bb} + (W+1)'(c); r = s[W-1:0]; f = s[W]; end
            3'd2: r = a & bb;
            3'd3: r = a | bb;
            3'd4: r = a ^ bb;
            3'd5: r = a;
            3'd6: f = (a < bb);
            default: f = (a == bb);
        endcase
        case (cfg_bit_fn)
            3'd0: o = f;
            3'd1: o = x;
            3'd2: o = ~x;
            3'd3: o = x & ya;
            3'd4: o = x | ya;
            3'd5: o = x ^ ya;
            3'd6: o = r[cfg_res_idx];
            default: o = 1'b0;
        endcase
        return {o, r};
    endfunction

    function automatic logic [NDIR-1:0] mask_of();
        logic [NDIR-1:0] m;
        m = '0;
        m[cfg_src_a] = 1'b1;
        if (cfg_mode == 2'd2) begin
            m[cfg_src_b] = 1'b1;
            m[cfg_lane_src] = 1'b1;
        end else if (cfg_mode != 2'd1) begin
            if (cfg_use_b && !cfg_bit2wide) m[cfg_src_b] = 1'b1;
            if (cfg_lane_en || cfg_bit2wide) m[cfg_lane_src] = 1'b1;
        end
        return m;
    endfunction

    task automatic set_cfg(input logic [1:0] md, input logic [2:0] op, input logic [1:0] sa,
                           input logic [1:0] sb, input logic ub, input logic [1:0] ls,
                           input logic le, input logic b2w, input logic ci,
                           input logic [2:0] fn, input logic [2:0] idx);
        cfg_mode = md; cfg_op = op; cfg_src_a = sa; cfg_src_b = sb; cfg_use_b = ub;
        cfg_lane_src = ls; cfg_lane_en = le; cfg_bit2wide = b2w; cfg_cin = ci;
        cfg_bit_fn = fn; cfg_res_idx = idx;
    endtask

    task automatic drive(input logic [W-1:0] a, input logic ya, input logic [W-1:0] b,
                         input logic x, input logic [NDIR-1:0] vmask);
        for (int i = 0; i < NDIR; i++) begin
            nb_data[i*W +: W] = 8'h5A ^ 8'(i * 37);
            nb_bit[i] = 1'(i & 1);
        end
        nb_bit[cfg_lane_src] = x;
        nb_data[cfg_src_b*W +: W] = b;
        nb_data[cfg_src_a*W +: W] = a;
        nb_bit[cfg_src_a] = ya;
        nb_valid = vmask;
    endtask

    task automatic push_exp(input string tag);
        exp_q.push_back(model(nb_data[cfg_src_a*W +: W], nb_bit[cfg_src_a],
                              nb_data[cfg_src_b*W +: W], nb_bit[cfg_lane_src]));
        tag_q.push_back(tag);
    endtask

    task automatic wait_accept(input string tag);
        logic [NDIR-1:0] m;
        m = mask_of();
        forever begin
            @(negedge clk);
            if (|nb_ready) begin
                // R12: ready raised exactly on the required channels
                check(nb_ready == m, {tag, " R12 ready mask"}, 9'(nb_ready), 9'(m));
                break;
            end
        end
        @(posedge clk); #1;
        nb_valid = '0;
    endtask

    task automatic send(input logic [W-1:0] a, input logic ya, input logic [W-1:0] b,
                        input logic x, input string tag);
        drive(a, ya, b, x, '1);
        push_exp(tag);
        wait_accept(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic tok, input logic [W-1:0] d, input logic b);
        @(posedge clk); #1;
        cfg_init_tok = tok; cfg_init_data = d; cfg_init_bit = b;
        rst = 1'b1; nb_valid = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected output token", {out_bit, out_data}, '0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check({out_bit, out_data} == mon_e, mon_t, {out_bit, out_data}, mon_e);
            end
        end
    end

    initial begin
        #(4 * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; out_ready = 1'b0; nb_valid = '0; nb_data = '0; nb_bit = '0;
        cfg_init_tok = 1'b0; cfg_init_data = '0; cfg_init_bit = 1'b0;
        set_cfg(2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);

        // R1: preloaded token
        do_reset(1'b1, 8'hA5, 1'b1);
        @(negedge clk);
        check(out_valid && out_data == 8'hA5 && out_bit, "R1 preload present after reset",
              {out_bit, out_data}, 9'h1A5);
        exp_q.push_back(9'h1A5); tag_q.push_back("R1 preload drains");
        @(posedge clk); #1 out_ready = 1'b1;
        idle(2);
        check(exp_q.size() == 0, "R1 preload delivered", 9'(exp_q.size()), '0);

        // R1: plain reset leaves the latch empty
        do_reset(1'b0, 8'h00, 1'b0);
        @(negedge clk);
        check(!out_valid, "R1 empty after reset", 9'(out_valid), '0);
        @(posedge clk); #1;

        // R3 R11: add with lane carry-in, then constant carry-in
        set_cfg(2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0);
        send(8'd200, 1'b0, 8'd100, 1'b1, "R3 R11 add lane carry");
        set_cfg(2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        send(8'd3, 1'b0, 8'd4, 1'b1, "R11 add ignores lane bit");
        // R3: subtract
        set_cfg(2'd0, 3'd1, 2'd0, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0);
        send(8'd10, 1'b0, 8'd3, 1'b0, "R3 sub no borrow");
        send(8'd3, 1'b0, 8'd10, 1'b0, "R3 sub borrow");
        // R4 R10: logic ops with single-bit functions
        set_cfg(2'd0, 3'd2, 2'd2, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 3'd0);
        send(8'hF0, 1'b1, 8'h3C, 1'b1, "R4 R10 and / bit and");
        set_cfg(2'd0, 3'd3, 2'd2, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd5, 3'd0);
        send(8'hF0, 1'b1, 8'h3C, 1'b0, "R4 R10 or / bit xor");
        set_cfg(2'd0, 3'd4, 2'd2, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd6, 3'd4);
        send(8'hF0, 1'b1, 8'h3C, 1'b1, "R4 R10 xor / result bit 4");
        set_cfg(2'd0, 3'd4, 2'd2, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd6, 3'd6);
        send(8'hF0, 1'b1, 8'h3C, 1'b1, "R4 R10 xor / result bit 6");
        set_cfg(2'd0, 3'd5, 2'd3, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd2, 3'd0);
        send(8'h81, 1'b0, 8'h00, 1'b0, "R4 R10 pass A / bit not");
        set_cfg(2'd0, 3'd0, 2'd3, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd7, 3'd0);
        send(8'hFF, 1'b0, 8'h01, 1'b1, "R10 bit zero on carrying add");
        set_cfg(2'd0, 3'd2, 2'd3, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0);
        send(8'h0F, 1'b0, 8'hFF, 1'b1, "R10 bit pass");
        set_cfg(2'd0, 3'd2, 2'd3, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd4, 3'd0);
        send(8'h0F, 1'b1, 8'hFF, 1'b0, "R10 bit or");
        // R5: compares
        set_cfg(2'd0, 3'd6, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        send(8'd5, 1'b0, 8'd9, 1'b0, "R5 less-than true");
        send(8'd9, 1'b0, 8'd5, 1'b0, "R5 less-than false");
        set_cfg(2'd0, 3'd7, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        send(8'h77, 1'b0, 8'h77, 1'b0, "R5 equal true");
        send(8'h77, 1'b0, 8'h78, 1'b0, "R5 equal false");
        // R7: forward
        set_cfg(2'd1, 3'd1, 2'd3, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 3'd7, 3'd0);
        send(8'h3E, 1'b1, 8'h11, 1'b0, "R7 forward");
        // R8: select
        set_cfg(2'd2, 3'd0, 2'd0, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        send(8'h11, 1'b0, 8'h22, 1'b1, "R8 select A");
        send(8'h11, 1'b0, 8'h22, 1'b0, "R8 select B");
        // R9: lane bit into the word unit
        set_cfg(2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0);
        send(8'hFF, 1'b0, 8'h55, 1'b1, "R9 lane bit as operand B");
        set_cfg(2'd0, 3'd6, 2'd1, 2'd2, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0);
        send(8'h00, 1'b0, 8'hFF, 1'b1, "R9 compare against lane bit");

        // R2: missing operand blocks acceptance
        idle(2);
        set_cfg(2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        drive(8'd20, 1'b0, 8'd22, 1'b0, 4'b0010);
        repeat (3) begin
            @(negedge clk);
            check(!out_valid && nb_ready == '0, "R2 waits for operand B",
                  {out_valid, 4'b0, nb_ready}, '0);
        end
        @(posedge clk); #1;
        nb_valid = 4'b0110;
        push_exp("R2 fires once B valid");
        wait_accept("R2 fires once B valid");

        // R6 R2: stalled consumer
        idle(2);
        out_ready = 1'b0;
        send(8'd1, 1'b0, 8'd2, 1'b0, "R6 first token through stall");
        fork
            send(8'd40, 1'b0, 8'd2, 1'b0, "R6 second token after stall");
            begin
                repeat (3) begin
                    @(negedge clk);
                    check(out_valid && {out_bit, out_data} == 9'h003 && nb_ready == '0,
                          "R6 R2 hold while stalled", {out_bit, out_data}, 9'h003);
                end
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join

        idle(4);
        check(exp_q.size() == 0, "R6 all tokens delivered", 9'(exp_q.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule